// File: doc/BRIEF.md
# Masked Multi-Field Flow Table Matcher

This block classifies packets against a table of sixteen rules. Each rule holds a value and a care mask over a header tuple of ten fields, an action, and a packet counter and a byte counter. A packet arrives as an already extracted tuple together with its length. All rules are compared in parallel. The rule with the lowest index among the matching rules supplies the action one clock later. In the following clock its counters advance by one packet and by the packet length. A packet that matches no rule gets the send-to-controller action.

A configuration port installs or disables one rule per cycle and reads back the counters of one entry. Installing a rule clears its counters. The action is a two-bit kind plus an output-port bitmap, so a forward action can replicate to several ports. Header parsing and the path toward the controller sit outside this block.

Top module: `flowtbl_top`

## Requirements
- R1: The key is packed with the fields in this order, most significant first: ingress port (8 bits), source MAC (48), destination MAC (48), EtherType (16), VLAN ID (12), IP source (32), IP destination (32), IP protocol (8), L4 source port (16), L4 destination port (16). An entry matches when it is valid and the key equals the stored value on every bit where the mask is 1. Mask bits at 0 are don't-care.
- R2: When several entries match, the one with the lowest index is reported.
- R3: One cycle after a sampled `pkt_valid`, `res_valid` is high and carries `res_hit`=1, the index, the kind and the port bitmap of the selected entry. Kind codes: 0 forward, 1 send to controller, 2 drop, 3 normal pipeline.
- R4: A packet matching no entry gives `res_hit`=0, kind 1, port bitmap 0 and index 0.
- R5: One cycle after a hit result, the selected entry's packet counter is one higher and its byte counter is higher by the packet length. A miss changes no counter.
- R6: Packets on consecutive cycles that select the same entry are all counted, with no lost update.
- R7: A configuration write installs valid flag, value, mask, kind and ports at the addressed entry and clears both of its counters. A write with the valid flag at 0 stops that entry from matching.
- R8: The counters of the entry addressed by `cfg_rd_idx` appear on `cfg_rd_pkts`/`cfg_rd_bytes` one cycle later.
- R9: After reset there is no result, every entry is invalid and every counter reads zero.
- R10: A cycle with `pkt_valid` low produces no result and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet tuple present this cycle |
| pkt_key | input | 236 | Packed header tuple |
| pkt_len | input | 16 | Packet length in bytes |
| res_valid | output | 1 | Classification result present |
| res_hit | output | 1 | A rule matched |
| res_idx | output | 4 | Index of the selected rule |
| res_kind | output | 2 | Action kind |
| res_ports | output | 8 | Output-port bitmap |
| cfg_wr_en | input | 1 | Rule write strobe |
| cfg_wr_idx | input | 4 | Entry to write |
| cfg_wr_valid | input | 1 | Valid flag for the written entry |
| cfg_wr_key | input | 236 | Match value |
| cfg_wr_mask | input | 236 | Care mask, 1 = compare |
| cfg_wr_kind | input | 2 | Action kind |
| cfg_wr_ports | input | 8 | Port bitmap |
| cfg_rd_idx | input | 4 | Entry whose counters are read |
| cfg_rd_pkts | output | 32 | Packet count read back |
| cfg_rd_bytes | output | 40 | Byte count read back |

## Verification
The bench sends packets that several rules match at once and checks that the earliest entry wins. A reversed or unordered priority encoder would report a later rule's drop or normal-pipeline action instead. Misses must yield the controller action with an empty bitmap; a design that forwards a stale bitmap or counts misses into entry 0 is caught by the counter reads. Bursts of packets to one entry on consecutive cycles expose a lost read-modify-write update. Rule rewrites must clear the counters, and an invalidated rule must let the packet fall to the next matching entry. A randomized phase with random masks and keys compares every result and all sixteen counter pairs against a behavioural model.

// File: rtl/flowtbl_pkg.sv
package flowtbl_pkg;

    localparam int W_INPORT = 8;
    localparam int W_MAC    = 48;
    localparam int W_ETYPE  = 16;
    localparam int W_VLAN   = 12;
    localparam int W_IP     = 32;
    localparam int W_PROTO  = 8;
    localparam int W_L4     = 16;

    typedef struct packed {
        logic [W_INPORT-1:0] in_port;
        logic [W_MAC-1:0]    mac_src;
        logic [W_MAC-1:0]    mac_dst;
        logic [W_ETYPE-1:0]  etype;
        logic [W_VLAN-1:0]   vlan;
        logic [W_IP-1:0]     ip_src;
        logic [W_IP-1:0]     ip_dst;
        logic [W_PROTO-1:0]  proto;
        logic [W_L4-1:0]     l4_src;
        logic [W_L4-1:0]     l4_dst;
    } hdr_t;

    localparam int KEY_W = $bits(hdr_t);

    typedef enum logic [1:0] {
        ACT_FWD    = 2'd0,
        ACT_CTRL   = 2'd1,
        ACT_DROP   = 2'd2,
        ACT_NORMAL = 2'd3
    } act_kind_e;

endpackage

// File: rtl/flowtbl_match.sv
module flowtbl_match #(
    parameter int N  = 16,
    parameter int KW = 8
) (
    input  logic [KW-1:0]         key,
    input  logic [N-1:0][KW-1:0]  vals,
    input  logic [N-1:0][KW-1:0]  masks,
    input  logic [N-1:0]          valids,
    output logic [N-1:0]          hits
);
    // One ternary comparator per entry, all evaluated in parallel.
    for (genvar e = 0; e < N; e++) begin : g_ent
        assign hits[e] = valids[e] && (((key ^ vals[e]) & masks[e]) == '0);
    end
endmodule

// File: rtl/flowtbl_prio.sv
module flowtbl_prio #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/flowtbl_top.sv
module flowtbl_top #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 8,
    parameter int LEN_W       = 16,
    parameter int PKT_CNT_W   = 32,
    parameter int BYTE_CNT_W  = 40,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int KW         = flowtbl_pkg::KEY_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pkt_valid,
    input  logic [KW-1:0]         pkt_key,
    input  logic [LEN_W-1:0]      pkt_len,
    output logic                  res_valid,
    output logic                  res_hit,
    output logic [IDX_W-1:0]      res_idx,
    output logic [1:0]            res_kind,
    output logic [NUM_PORTS-1:0]  res_ports,
    input  logic                  cfg_wr_en,
    input  logic [IDX_W-1:0]      cfg_wr_idx,
    input  logic                  cfg_wr_valid,
    input  logic [KW-1:0]         cfg_wr_key,
    input  logic [KW-1:0]         cfg_wr_mask,
    input  logic [1:0]            cfg_wr_kind,
    input  logic [NUM_PORTS-1:0]  cfg_wr_ports,
    input  logic [IDX_W-1:0]      cfg_rd_idx,
    output logic [PKT_CNT_W-1:0]  cfg_rd_pkts,
    output logic [BYTE_CNT_W-1:0] cfg_rd_bytes
);
    import flowtbl_pkg::*;

    localparam int N = NUM_ENTRIES;

    typedef struct packed {
        logic [N-1:0]                 ent_valid;
        logic [N-1:0][KW-1:0]         ent_val;
        logic [N-1:0][KW-1:0]         ent_mask;
        logic [N-1:0][1:0]            ent_kind;
        logic [N-1:0][NUM_PORTS-1:0]  ent_ports;
        logic [N-1:0][PKT_CNT_W-1:0]  pkts;
        logic [N-1:0][BYTE_CNT_W-1:0] bytes;
        logic                         res_valid;
        logic                         res_hit;
        logic [IDX_W-1:0]             res_idx;
        logic [1:0]                   res_kind;
        logic [NUM_PORTS-1:0]         res_ports;
        logic [LEN_W-1:0]             res_len;
        logic [PKT_CNT_W-1:0]         rd_pkts;
        logic [BYTE_CNT_W-1:0]        rd_bytes;
    } state_t;

    state_t state_d, state_q;

    logic [N-1:0]     hit_vec;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;

    flowtbl_match #(.N(N), .KW(KW)) u_match (
        .key    (pkt_key),
        .vals   (state_q.ent_val),
        .masks  (state_q.ent_mask),
        .valids (state_q.ent_valid),
        .hits   (hit_vec)
    );

    flowtbl_prio #(.N(N), .IW(IDX_W)) u_prio (
        .req (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    always_comb begin
        state_d = state_q;

        // Stage 1: register the classification result.
        state_d.res_valid = pkt_valid;
        state_d.res_hit   = pkt_valid && hit_any;
        state_d.res_idx   = hit_any ? hit_idx : '0;
        state_d.res_kind  = hit_any ? state_q.ent_kind[hit_idx] : ACT_CTRL;
        state_d.res_ports = hit_any ? state_q.ent_ports[hit_idx] : '0;
        state_d.res_len   = pkt_len;

        // Stage 2: counter read-modify-write from the registered result.
        // The whole array is a register, so consecutive updates chain.
        if (state_q.res_valid && state_q.res_hit) begin
            state_d.pkts[state_q.res_idx]  = state_q.pkts[state_q.res_idx] + PKT_CNT_W'(1);
            state_d.bytes[state_q.res_idx] = state_q.bytes[state_q.res_idx]
                                           + BYTE_CNT_W'(state_q.res_len);
        end

        // Configuration write takes precedence and clears the counters.
        if (cfg_wr_en) begin
            state_d.ent_valid[cfg_wr_idx] = cfg_wr_valid;
            state_d.ent_val[cfg_wr_idx]   = cfg_wr_key;
            state_d.ent_mask[cfg_wr_idx]  = cfg_wr_mask;
            state_d.ent_kind[cfg_wr_idx]  = cfg_wr_kind;
            state_d.ent_ports[cfg_wr_idx] = cfg_wr_ports;
            state_d.pkts[cfg_wr_idx]      = '0;
            state_d.bytes[cfg_wr_idx]     = '0;
        end

        state_d.rd_pkts  = state_q.pkts[cfg_rd_idx];
        state_d.rd_bytes = state_q.bytes[cfg_rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_valid    = state_q.res_valid;
    assign res_hit      = state_q.res_hit;
    assign res_idx      = state_q.res_idx;
    assign res_kind     = state_q.res_kind;
    assign res_ports    = state_q.res_ports;
    assign cfg_rd_pkts  = state_q.rd_pkts;
    assign cfg_rd_bytes = state_q.rd_bytes;

endmodule

// File: rtl/flowtbl_chk.sv
module flowtbl_chk #(
    parameter int N  = 16,
    parameter int IW = 4,
    parameter int NP = 8,
    parameter int PW = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pkt_valid,
    input logic [N-1:0]        match_vec,
    input logic                res_valid,
    input logic                res_hit,
    input logic [IW-1:0]       res_idx,
    input logic [1:0]          res_kind,
    input logic [NP-1:0]       res_ports,
    input logic                cfg_wr_en,
    input logic [IW-1:0]       cfg_wr_idx,
    input logic [N-1:0][PW-1:0] pkts
);
    logic [N-1:0] mv_q;
    logic [N-1:0] below;

    always_ff @(posedge clk) begin
        if (!rst_n) mv_q <= '0;
        else        mv_q <= match_vec;
    end

    always_comb below = (N'(1) << res_idx) - N'(1);

    // R3: every sampled packet yields a result one cycle later
    a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> res_valid);

    // R10: no packet, no result
    a_r10_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> !res_valid);

    // R1: hit flag agrees with the comparator outputs of the sampled cycle
    a_r1_hit_iff_match: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit == (|mv_q)));

    // R2: reported entry matched and no lower entry matched
    a_r2_first_match: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (mv_q[res_idx] && ((mv_q & below) == '0)));

    // R4: misses default to the controller action with no ports
    a_r4_miss_default: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_kind == 2'd1 && res_ports == '0));

    // R5: hit advances the selected packet counter by one
    a_r5_pkt_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && !(cfg_wr_en && cfg_wr_idx == res_idx))
        |=> (pkts[$past(res_idx)] == $past(pkts[res_idx]) + PW'(1)));

endmodule

bind flowtbl_top flowtbl_chk #(
    .N  (NUM_ENTRIES),
    .IW (IDX_W),
    .NP (NUM_PORTS),
    .PW (PKT_CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .match_vec  (hit_vec),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_idx    (res_idx),
    .res_kind   (res_kind),
    .res_ports  (res_ports),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_idx (cfg_wr_idx),
    .pkts       (state_q.pkts)
);

// File: tb/tb_flowtbl_top.sv
module tb_flowtbl_top;
    import flowtbl_pkg::*;

    localparam int KW = KEY_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pkt_valid = 1'b0;
    logic [KW-1:0]   pkt_key = '0;
    logic [15:0]     pkt_len = '0;
    logic            res_valid, res_hit;
    logic [3:0]      res_idx;
    logic [1:0]      res_kind;
    logic [7:0]      res_ports;
    logic            cfg_wr_en = 1'b0;
    logic [3:0]      cfg_wr_idx = '0;
    logic            cfg_wr_valid = 1'b0;
    logic [KW-1:0]   cfg_wr_key = '0;
    logic [KW-1:0]   cfg_wr_mask = '0;
    logic [1:0]      cfg_wr_kind = '0;
    logic [7:0]      cfg_wr_ports = '0;
    logic [3:0]      cfg_rd_idx = '0;
    logic [31:0]     cfg_rd_pkts;
    logic [39:0]     cfg_rd_bytes;

    always #5 clk = ~clk;

    flowtbl_top dut (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_key(pkt_key), .pkt_len(pkt_len),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_kind(res_kind), .res_ports(res_ports),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_valid(cfg_wr_valid),
        .cfg_wr_key(cfg_wr_key), .cfg_wr_mask(cfg_wr_mask), .cfg_wr_kind(cfg_wr_kind),
        .cfg_wr_ports(cfg_wr_ports), .cfg_rd_idx(cfg_rd_idx),
        .cfg_rd_pkts(cfg_rd_pkts), .cfg_rd_bytes(cfg_rd_bytes)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    hdr_t        m_val   [16];
    hdr_t        m_mask  [16];
    logic        m_valid [16];
    logic [1:0]  m_kind  [16];
    logic [7:0]  m_ports [16];
    logic [31:0] m_pkts  [16];
    logic [39:0] m_bytes [16];

    typedef struct packed {
        logic [31:0] ipd;
        logic [15:0] dport;
        logic [15:0] et;
        logic [15:0] len;
        logic        hit;
        logic [3:0]  idx;
        logic [1:0]  kind;
        logic [7:0]  ports;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0A000001, 16'd80,  16'h0800, 16'd64,   1'b1, 4'd0,  2'd0, 8'h05},
        '{32'h0A000002, 16'd80,  16'h0800, 16'd100,  1'b1, 4'd1,  2'd2, 8'h00},
        '{32'h0B000001, 16'd80,  16'h0800, 16'd1500, 1'b1, 4'd2,  2'd3, 8'h00},
        '{32'h0B000001, 16'd443, 16'h0800, 16'd60,   1'b0, 4'd0,  2'd1, 8'h00},
        '{32'h0B000001, 16'd443, 16'h0806, 16'd42,   1'b1, 4'd15, 2'd0, 8'h80},
        '{32'h0A000001, 16'd443, 16'h0806, 16'd70,   1'b1, 4'd0,  2'd0, 8'h05},
        '{32'h0C000000, 16'd22,  16'h0800, 16'd1000, 1'b0, 4'd0,  2'd1, 8'h00},
        '{32'h0B000000, 16'd80,  16'h0806, 16'd300,  1'b1, 4'd2,  2'd3, 8'h00}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_rule(input int idx, input logic v, input hdr_t val, input hdr_t msk,
                              input logic [1:0] kind, input logic [7:0] ports);
        cfg_wr_en = 1'b1; cfg_wr_idx = 4'(idx); cfg_wr_valid = v;
        cfg_wr_key = val; cfg_wr_mask = msk; cfg_wr_kind = kind; cfg_wr_ports = ports;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_val[idx] = val; m_mask[idx] = msk; m_valid[idx] = v;
        m_kind[idx] = kind; m_ports[idx] = ports; m_pkts[idx] = '0; m_bytes[idx] = '0;
    endtask

    // Drive at a negedge; result is visible at the next negedge.
    task automatic step(input logic v, input hdr_t key, input logic [15:0] len);
        pkt_valid = v; pkt_key = key; pkt_len = len;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic read_cnt(input int idx, output logic [31:0] p, output logic [39:0] b);
        pkt_valid = 1'b0;
        @(negedge clk);
        cfg_rd_idx = 4'(idx);
        @(negedge clk);
        p = cfg_rd_pkts; b = cfg_rd_bytes;
    endtask

    task automatic model_lookup(input hdr_t key, output logic hit, output int idx);
        hit = 1'b0; idx = 0;
        for (int e = 15; e >= 0; e--) begin
            if (m_valid[e] && (((key ^ m_val[e]) & m_mask[e]) == '0)) begin
                hit = 1'b1; idx = e;
            end
        end
    endtask

    function automatic hdr_t rand_hdr();
        logic [255:0] r;
        r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return hdr_t'(r[KW-1:0]);
    endfunction

    function automatic hdr_t rand_mask();
        hdr_t m = '0;
        if ($urandom % 3 == 0) m.in_port = '1;
        if ($urandom % 4 == 0) m.mac_dst = '1;
        if ($urandom % 3 == 0) m.etype   = '1;
        if ($urandom % 4 == 0) m.vlan    = '1;
        if ($urandom % 3 == 0) m.ip_dst  = '1;
        if ($urandom % 4 == 0) m.proto   = '1;
        if ($urandom % 3 == 0) m.l4_dst  = '1;
        if (m == '0) m.l4_src = '1;
        return m;
    endfunction

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        hdr_t        h, m;
        logic [31:0] p;
        logic [39:0] b;
        logic        ehit;
        int          eidx;

        for (int e = 0; e < 16; e++) begin
            m_valid[e] = 1'b0; m_pkts[e] = '0; m_bytes[e] = '0;
            m_val[e] = '0; m_mask[e] = '0; m_kind[e] = '0; m_ports[e] = '0;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 res_valid after reset", 64'(res_valid), 64'd0);
        read_cnt(0, p, b);
        chk("R9 pkts after reset", 64'(p), 64'd0);
        chk("R9 bytes after reset", 64'(b), 64'd0);
        h = '0; h.ip_dst = 32'h0A000001;
        step(1'b1, h, 16'd64);
        chk("R9 empty table gives miss", 64'(res_hit), 64'd0);
        chk("R4 miss kind", 64'(res_kind), 64'd1);
        chk("R4 miss ports", 64'(res_ports), 64'd0);

        // Directed rule set
        h = '0; m = '0; h.ip_dst = 32'h0A000001; m.ip_dst = '1;
        write_rule(0, 1'b1, h, m, 2'd0, 8'h05);
        h = '0; m = '0; h.ip_dst = 32'h0A000000; m.ip_dst = 32'hFF000000;
        write_rule(1, 1'b1, h, m, 2'd2, 8'h00);
        h = '0; m = '0; h.l4_dst = 16'd80; m.l4_dst = '1;
        write_rule(2, 1'b1, h, m, 2'd3, 8'h00);
        h = '0; m = '0; h.etype = 16'h0806; m.etype = '1;
        write_rule(15, 1'b1, h, m, 2'd0, 8'h80);

        // Vector table: R1, R2, R3, R4
        for (int i = 0; i < 8; i++) begin
            h = '0; h.ip_dst = VECS[i].ipd; h.l4_dst = VECS[i].dport; h.etype = VECS[i].et;
            step(1'b1, h, VECS[i].len);
            chk("R3 res_valid", 64'(res_valid), 64'd1);
            chk("R1 hit", 64'(res_hit), 64'(VECS[i].hit));
            chk("R2 idx", 64'(res_idx), 64'(VECS[i].idx));
            chk("R3 kind", 64'(res_kind), 64'(VECS[i].kind));
            chk("R3 ports", 64'(res_ports), 64'(VECS[i].ports));
            if (VECS[i].hit) begin
                m_pkts[VECS[i].idx]  += 1;
                m_bytes[VECS[i].idx] += 40'(VECS[i].len);
            end
        end

        // R5, R8: counters after the table
        for (int e = 0; e < 16; e++) begin
            read_cnt(e, p, b);
            chk("R5 pkts", 64'(p), 64'(m_pkts[e]));
            chk("R8 bytes", 64'(b), 64'(m_bytes[e]));
        end

        // R6: back-to-back packets on entry 0
        h = '0; h.ip_dst = 32'h0A000001;
        for (int k = 1; k <= 3; k++) begin
            pkt_valid = 1'b1; pkt_key = h; pkt_len = 16'(k * 10);
            @(negedge clk);
            chk("R6 burst idx", 64'(res_idx), 64'd0);
            m_pkts[0] += 1; m_bytes[0] += 40'(k * 10);
        end
        pkt_valid = 1'b0;
        read_cnt(0, p, b);
        chk("R6 burst pkts", 64'(p), 64'(m_pkts[0]));
        chk("R6 burst bytes", 64'(b), 64'(m_bytes[0]));

        // R10: matching key with pkt_valid low
        pkt_key = h; pkt_len = 16'd999;
        @(negedge clk);
        chk("R10 no result", 64'(res_valid), 64'd0);
        read_cnt(0, p, b);
        chk("R10 pkts unchanged", 64'(p), 64'(m_pkts[0]));

        // R7: rewrite clears, invalid entry falls through
        h = '0; m = '0; h.ip_dst = 32'h0A000001; m.ip_dst = '1;
        write_rule(0, 1'b1, h, m, 2'd0, 8'h05);
        read_cnt(0, p, b);
        chk("R7 rewrite clears pkts", 64'(p), 64'd0);
        chk("R7 rewrite clears bytes", 64'(b), 64'd0);
        write_rule(0, 1'b0, h, m, 2'd0, 8'h05);
        h.l4_dst = 16'd443; h.etype = 16'h0800;
        step(1'b1, h, 16'd50);
        chk("R7 invalid entry skipped idx", 64'(res_idx), 64'd1);
        chk("R7 invalid entry skipped kind", 64'(res_kind), 64'd2);
        m_pkts[1] += 1; m_bytes[1] += 40'd50;
        read_cnt(0, p, b);
        chk("R7 invalid entry not counted", 64'(p), 64'd0);

        // Randomized phase: R1, R2, R5
        for (int e = 0; e < 16; e++) begin
            write_rule(e, ($urandom % 6) != 0, rand_hdr(), rand_mask(),
                       2'($urandom), 8'($urandom));
        end
        for (int i = 0; i < 300; i++) begin
            int r = int'($urandom % 16);
            logic [15:0] len = 16'($urandom % 1500) + 16'd40;
            if ($urandom % 4 != 0) h = m_val[r] ^ (rand_hdr() & ~m_mask[r]);
            else                   h = rand_hdr();
            model_lookup(h, ehit, eidx);
            pkt_valid = 1'b1; pkt_key = h; pkt_len = len;
            @(negedge clk);
            chk("R1 random hit", 64'(res_hit), 64'(ehit));
            chk("R2 random idx", 64'(res_idx), 64'(ehit ? eidx : 0));
            chk("R3 random kind", 64'(res_kind), 64'(ehit ? m_kind[eidx] : 2'd1));
            chk("R3 random ports", 64'(res_ports), 64'(ehit ? m_ports[eidx] : 8'd0));
            if (ehit) begin
                m_pkts[eidx] += 1; m_bytes[eidx] += 40'(len);
            end
        end
        pkt_valid = 1'b0;
        for (int e = 0; e < 16; e++) begin
            read_cnt(e, p, b);
            chk("R5 random pkts", 64'(p), 64'(m_pkts[e]));
            chk("R5 random bytes", 64'(b), 64'(m_bytes[e]));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule